// File: doc/BRIEF.md
# SPI Potentiometer Command Decoder

This block is the serial slave front end of a digitally controlled potentiometer. It oversamples the four host lines (serial clock, serial data in, active-low chip select and active-low pause) with the much faster system clock. It then parses each selected frame, which is an identification byte, an instruction byte and, for some commands, a data byte. From that it issues single-cycle request strobes to the neighbouring blocks that hold the wiper register and the four stored data registers.

Each strobe carries a command code, a register index and, where relevant, write data or a step direction. For read commands the block takes the requested value from the neighbours and shifts it out MSB first on the serial output, along with an output-enable that stands in for the pad's tristate control. An increment/decrement command opens a stream in which every serial clock pulse becomes one step request until chip select rises. The pause input freezes the frame without losing its position.

Top module: `dpot_serial_front`

## Requirements
- R1: After reset no strobe is issued and SO stays disabled until the block has seen chip select go from high to low; a frame already in progress at reset is ignored.
- R2: The first byte of a frame (MSB first) must be 0101110 followed by a bit equal to `addr_pin_i`. On any mismatch the rest of the frame gives no strobe and no SO enable.
- R3: The instruction byte is I3 I2 I1 I0 R1 R0 x x, and R1:R0 drive `reg_sel_o`. The upper nibble selects the command with these `cmd_o` codes: 1001 read wiper = 0, 1010 write wiper = 1, 1011 read data register = 2, 1100 write data register = 3, 1101 data register to wiper = 4, 1110 wiper to data register = 5, 0010 step stream = 6. The full byte 0101_0001 is read status = 7.
- R4: The two transfer commands strobe once when the instruction byte completes, with `reg_sel_o` = R1:R0, and end the frame without enabling SO.
- R5: The write commands take a third byte and strobe when its last bit arrives. `wr_data_o` is the low six bits of that byte, and the top two bits are ignored.
- R6: The read commands strobe when the instruction byte completes. During the third byte SO carries {2'b00, value} MSB first, where value is `wcr_i` for a wiper read and `dr_i` for a data register read. `reg_sel_o` stays constant during the output byte.
- R7: Read status strobes with code 7 and shifts out {7'b0, `wip_i`}.
- R8: After a step instruction, each rising serial clock edge strobes code 6 with `step_up_o` equal to SI at that edge, until chip select rises.
- R9: SI is taken on rising serial clock edges, and SO changes only after falling edges. SO enable is low whenever chip select is high and outside the output byte of a read.
- R10: The pause input going low while the serial clock is low disables SO and makes clock edges ignored. Going high again while the clock is low resumes the frame where it stopped.
- R11: An instruction byte that matches none of the codes in R3 gives no strobe and leaves SO disabled for the rest of the frame.
- R12: In reset, `so_en_o` and `cmd_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| csn_i | input | 1 | Chip select, active low |
| holdn_i | input | 1 | Pause request, active low |
| addr_pin_i | input | 1 | Strap value the identification byte LSB must match |
| wcr_i | input | 6 | Current wiper register value |
| dr_i | input | 6 | Contents of the data register picked by `reg_sel_o` |
| wip_i | input | 1 | Nonvolatile write in progress |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Drive enable for SO; low means high impedance |
| cmd_stb_o | output | 1 | One-cycle request strobe |
| cmd_o | output | 3 | Command code of the request (see R3) |
| reg_sel_o | output | 2 | Data register index from R1:R0 |
| wr_data_o | output | 6 | Write data for write requests |
| step_up_o | output | 1 | Step direction, 1 toward the high end |

## Verification
A wrong frame phase or bit count shows at the ports within one serial byte. It appears as a strobe on the wrong bit, a missing strobe, or an SO byte that is shifted by one place. A lost pause state shows as a strobe or an SO enable while the pause is held. A stale edge history shows as an extra step or a shifted output bit on the first serial clock edge after resuming. Wrong decode shows as a bad `cmd_o` or `reg_sel_o` in the strobe cycle itself. So each directed frame compares the strobe fields and the returned SO byte against values derived from the requirements.

// File: rtl/dpot_fe_pkg.sv
// Shared constants and types for the potentiometer serial front end.
package dpot_fe_pkg;
    localparam int BYTE_W  = 8;
    localparam int DATA_W  = 6;
    localparam int SEL_W   = 2;
    localparam int CNT_W   = $clog2(BYTE_W);
    localparam logic [BYTE_W-2:0] DEV_TYPE = 7'b0101110;

    // Request codes presented on cmd_o
    typedef enum logic [2:0] {
        CMD_RD_WCR  = 3'd0,
        CMD_WR_WCR  = 3'd1,
        CMD_RD_DR   = 3'd2,
        CMD_WR_DR   = 3'd3,
        CMD_DR2WCR  = 3'd4,
        CMD_WCR2DR  = 3'd5,
        CMD_STEP    = 3'd6,
        CMD_RD_STAT = 3'd7
    } cmd_e;

    // Position within a selected frame
    typedef enum logic [2:0] {
        PH_IDLE, PH_ID, PH_INSTR, PH_WDATA, PH_RDATA, PH_STEP, PH_DROP
    } phase_e;

    typedef struct packed {
        logic ok;
        cmd_e op;
    } dec_t;
endpackage

// File: rtl/dpot_sync.sv
// Multi-stage synchronizer, one chain per input bit.
// Assumes: inputs are asynchronous to clk; RST_VAL gives each chain's reset level.
module dpot_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw input through the chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
            else        chain <= {chain[STAGES-2:0], d[g]};
        end
        assign q[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/dpot_frame_parser.sv
// Frame parser: finds serial clock edges, counts bits, checks the
// identification byte, decodes the instruction and issues request strobes.
// Assumes: inputs already synchronized; clk at least 8x the serial clock.
module dpot_frame_parser
    import dpot_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              csn_s,
    input  logic              holdn_s,
    input  logic              addr_pin,
    output logic              cmd_stb,
    output cmd_e              cmd,
    output logic [SEL_W-1:0]  reg_sel,
    output logic [DATA_W-1:0] wr_data,
    output logic              step_up,
    output logic              rd_phase,
    output logic              rd_fall,
    output logic              paused
);
    logic              sck_d, csn_d;
    phase_e            st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-2:0] sh;
    logic [BYTE_W-1:0] byte_nx;
    logic              live, rise, fall, csn_fall, last_bit;
    dec_t              dec;

    // Map an instruction byte to a request code
    function automatic dec_t decode_op(input logic [BYTE_W-1:0] b);
        dec_t r;
        r.ok = 1'b1;
        r.op = CMD_RD_WCR;
        case (b[7:4])
            4'b1001: r.op = CMD_RD_WCR;
            4'b1010: r.op = CMD_WR_WCR;
            4'b1011: r.op = CMD_RD_DR;
            4'b1100: r.op = CMD_WR_DR;
            4'b1101: r.op = CMD_DR2WCR;
            4'b1110: r.op = CMD_WCR2DR;
            4'b0010: r.op = CMD_STEP;
            4'b0101: begin
                r.op = CMD_RD_STAT;
                r.ok = (b[3:0] == 4'b0001);
            end
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction

    assign byte_nx  = {sh, si_s};
    assign dec      = decode_op(byte_nx);
    assign live     = !csn_s && !paused;
    assign rise     = live && sck_s && !sck_d;
    assign fall     = live && !sck_s && sck_d;
    assign csn_fall = csn_d && !csn_s;
    assign last_bit = (cnt == CNT_W'(BYTE_W - 1));
    assign rd_phase = (st == PH_RDATA);
    assign rd_fall  = rd_phase && fall;

    // Edge history for clock and chip select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            csn_d <= 1'b0;
        end else begin
            sck_d <= sck_s;
            csn_d <= csn_s;
        end
    end

    // Pause state: entered and left only while the serial clock is low
    always_ff @(posedge clk) begin
        if (!rst_n || csn_s)               paused <= 1'b0;
        else if (!paused && !holdn_s && !sck_s) paused <= 1'b1;
        else if (paused && holdn_s && !sck_s)   paused <= 1'b0;
    end

    // Frame sequencing, decode and request strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= PH_IDLE;
            cnt     <= '0;
            sh      <= '0;
            cmd_stb <= 1'b0;
            cmd     <= CMD_RD_WCR;
            reg_sel <= '0;
            wr_data <= '0;
            step_up <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            if (csn_s) begin
                st <= PH_IDLE;
            end else if (csn_fall) begin
                st  <= PH_ID;
                cnt <= '0;
            end else if (rise) begin
                case (st)
                    PH_ID, PH_INSTR, PH_WDATA: begin
                        sh  <= byte_nx[BYTE_W-2:0];
                        cnt <= cnt + 1'b1;
                        if (last_bit) begin
                            if (st == PH_ID) begin
                                st <= (byte_nx == {DEV_TYPE, addr_pin}) ? PH_INSTR : PH_DROP;
                            end else if (st == PH_WDATA) begin
                                cmd_stb <= 1'b1;
                                wr_data <= byte_nx[DATA_W-1:0];
                                st      <= PH_DROP;
                            end else if (!dec.ok) begin
                                st <= PH_DROP;
                            end else begin
                                cmd     <= dec.op;
                                reg_sel <= byte_nx[3:2];
                                case (dec.op)
                                    CMD_WR_WCR, CMD_WR_DR: st <= PH_WDATA;
                                    CMD_STEP:              st <= PH_STEP;
                                    CMD_DR2WCR, CMD_WCR2DR: begin
                                        cmd_stb <= 1'b1;
                                        st      <= PH_DROP;
                                    end
                                    default: begin
                                        cmd_stb <= 1'b1;
                                        st      <= PH_RDATA;
                                    end
                                endcase
                            end
                        end
                    end
                    PH_RDATA: begin
                        cnt <= cnt + 1'b1;
                        if (last_bit) st <= PH_DROP;
                    end
                    PH_STEP: begin
                        cmd_stb <= 1'b1;
                        cmd     <= CMD_STEP;
                        step_up <= si_s;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8: strobes last exactly one cycle
    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);
    // R1: a strobe only follows a selected cycle
    p_strobe_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> !$past(csn_s));
    // R10: no request while paused
    p_hold_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        paused |-> !cmd_stb);
    // R6: register index steady while a read byte is shifted out
    p_sel_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_phase && $past(rd_phase)) |-> $stable(reg_sel));
endmodule

// File: rtl/dpot_so_shift.sv
// Serial output shifter: loads the read word on the first falling clock edge
// of the output byte and shifts it MSB first on later falling edges.
// Assumes: wcr/dr/wip are stable from the read strobe to the end of the byte.
module dpot_so_shift
    import dpot_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_phase,
    input  logic              rd_fall,
    input  logic              paused,
    input  logic              csn_s,
    input  cmd_e              cmd,
    input  logic [DATA_W-1:0] wcr,
    input  logic [DATA_W-1:0] dr,
    input  logic              wip,
    output logic              so,
    output logic              so_en
);
    localparam int PAD_W = BYTE_W - DATA_W;

    logic [BYTE_W-1:0] word, obuf;
    logic              loaded;

    // Select the byte returned for the current read
    always_comb begin
        case (cmd)
            CMD_RD_STAT: word = {{(BYTE_W-1){1'b0}}, wip};
            CMD_RD_WCR:  word = {{PAD_W{1'b0}}, wcr};
            default:     word = {{PAD_W{1'b0}}, dr};
        endcase
    end

    // Load then shift on falling serial clock edges
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_phase) begin
            loaded <= 1'b0;
            obuf   <= '0;
        end else if (rd_fall) begin
            loaded <= 1'b1;
            obuf   <= loaded ? {obuf[BYTE_W-2:0], 1'b0} : word;
        end
    end

    assign so    = obuf[BYTE_W-1];
    assign so_en = rd_phase && loaded && !paused;

    // R9: output released one cycle after deselect at the latest
    p_quiet_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !so_en);
    // R9: SO only moves on a falling clock edge of a read
    p_so_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (so_en && $past(so_en) && !$past(rd_fall)) |-> $stable(so));
endmodule

// File: rtl/dpot_serial_front.sv
// Top of the potentiometer serial front end: synchronizers, frame parser and
// SO shifter. Assumes clk runs at least 8x the serial clock.
module dpot_serial_front
    import dpot_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              sdi_i,
    input  logic              csn_i,
    input  logic              holdn_i,
    input  logic              addr_pin_i,
    input  logic [DATA_W-1:0] wcr_i,
    input  logic [DATA_W-1:0] dr_i,
    input  logic              wip_i,
    output logic              so_o,
    output logic              so_en_o,
    output logic              cmd_stb_o,
    output logic [2:0]        cmd_o,
    output logic [SEL_W-1:0]  reg_sel_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              step_up_o
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] raw, syn;
    logic             rd_phase, rd_fall, paused;
    cmd_e             cmd;

    assign raw = {holdn_i, csn_i, sck_i, sdi_i};

    // Chip select resets low so a frame open at reset is not taken as a start
    dpot_sync #(.W(NSYNC), .STAGES(2), .RST_VAL(4'b1000)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    dpot_frame_parser i_parser (
        .clk(clk), .rst_n(rst_n),
        .sck_s(syn[1]), .si_s(syn[0]), .csn_s(syn[2]), .holdn_s(syn[3]),
        .addr_pin(addr_pin_i),
        .cmd_stb(cmd_stb_o), .cmd(cmd), .reg_sel(reg_sel_o),
        .wr_data(wr_data_o), .step_up(step_up_o),
        .rd_phase(rd_phase), .rd_fall(rd_fall), .paused(paused)
    );

    dpot_so_shift i_shift (
        .clk(clk), .rst_n(rst_n),
        .rd_phase(rd_phase), .rd_fall(rd_fall), .paused(paused), .csn_s(syn[2]),
        .cmd(cmd), .wcr(wcr_i), .dr(dr_i), .wip(wip_i),
        .so(so_o), .so_en(so_en_o)
    );

    assign cmd_o = cmd;
endmodule

// File: tb/test_dpot_serial_front.sv
// Directed bench for the potentiometer serial front end.
module test_dpot_serial_front;
    localparam int H = 8;          // serial clock half period in system clocks
    localparam logic [7:0] ID_OK  = 8'h5D;   // 0101110 + addr 1
    localparam logic [7:0] ID_BAD = 8'h5C;   // address bit 0

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, sdi = 1'b0, csn = 1'b0, holdn = 1'b1;
    logic [5:0] wcr = 6'h15;
    logic [5:0] dr;
    logic       wip = 1'b1;
    logic so_o, so_en_o, cmd_stb_o, step_up_o;
    logic [2:0] cmd_o;
    logic [1:0] reg_sel_o;
    logic [5:0] wr_data_o;

    int checks = 0, fails = 0;
    int stb_cnt = 0, ups = 0, downs = 0, en_cnt = 0;
    int last_cmd = -1, last_sel = -1, last_data = -1;

    always #10 clk = ~clk;
    assign dr = {4'b1010, reg_sel_o};

    dpot_serial_front i_dpot_serial_front (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .csn_i(csn),
        .holdn_i(holdn), .addr_pin_i(1'b1), .wcr_i(wcr), .dr_i(dr), .wip_i(wip),
        .so_o(so_o), .so_en_o(so_en_o), .cmd_stb_o(cmd_stb_o), .cmd_o(cmd_o),
        .reg_sel_o(reg_sel_o), .wr_data_o(wr_data_o), .step_up_o(step_up_o)
    );

    // Record strobes and SO enables away from the active edge
    always @(negedge clk) begin
        if (so_en_o) en_cnt++;
        if (cmd_stb_o) begin
            stb_cnt++;
            last_cmd  = cmd_o;
            last_sel  = reg_sel_o;
            last_data = wr_data_o;
            if (cmd_o == 3'd6) begin
                if (step_up_o) ups++; else downs++;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cs_begin();
        csn = 1'b0;
        tick(H);
    endtask

    task automatic cs_end();
        tick(H);
        csn = 1'b1;
        tick(2 * H);
    endtask

    // One byte MSB first; optional pause before bit hold_at
    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx,
                            output logic en_seen, input int hold_at);
        en_seen = 1'b0;
        rx = '0;
        for (int i = 7; i >= 0; i--) begin
            if (i == hold_at) begin
                holdn = 1'b0;
                tick(H);
                chk("R10 SO disabled while paused", so_en_o, 0);
                for (int k = 0; k < 2; k++) begin
                    sck = 1'b1; tick(H); sck = 1'b0; tick(H);
                end
                chk("R10 no strobe while paused", stb_cnt, 1);
                holdn = 1'b1;
                tick(H);
            end
            sdi = tx[i];
            tick(H);
            rx[i] = so_o;
            en_seen |= so_en_o;
            sck = 1'b1;
            tick(H);
            sck = 1'b0;
        end
    endtask

    task automatic pulse(input logic v);
        sdi = v; tick(H); sck = 1'b1; tick(H); sck = 1'b0;
    endtask

    // Full frame helper: id, instruction, optional third byte
    task automatic frame(input logic [7:0] id, input logic [7:0] ins,
                         input bit third, input logic [7:0] tx3,
                         output logic [7:0] rx, output logic en3);
        logic [7:0] dummy;
        logic e;
        cs_begin();
        spi_byte(id, dummy, e, -1);
        spi_byte(ins, dummy, e, -1);
        rx = '0; en3 = 1'b0;
        if (third) spi_byte(tx3, rx, en3, -1);
        cs_end();
    endtask

    task automatic t_reset_and_start();
        logic [7:0] rx; logic e, dummy_e;
        logic [7:0] d;
        tick(3);
        chk("R12 so_en in reset", so_en_o, 0);
        chk("R12 strobe in reset", cmd_stb_o, 0);
        rst_n = 1'b1;
        tick(2);
        // csn already low: frame without a prior falling edge
        spi_byte(ID_OK, d, dummy_e, -1);
        spi_byte(8'hA0, d, dummy_e, -1);
        spi_byte(8'h2B, rx, e, -1);
        chk("R1 no strobe without CS fall", stb_cnt, 0);
        csn = 1'b1;
        tick(2 * H);
        chk("R9 SO off with CS high", so_en_o, 0);
    endtask

    task automatic t_writes();
        logic [7:0] rx; logic e;
        frame(ID_OK, 8'hA0, 1, 8'h2B, rx, e);
        chk("R5 write wiper strobes", stb_cnt, 1);
        chk("R3 write wiper code", last_cmd, 1);
        chk("R5 write wiper data", last_data, 6'h2B);
        frame(ID_OK, 8'hCC, 1, 8'hFF, rx, e);
        chk("R3 write DR code", last_cmd, 3);
        chk("R3 write DR select", last_sel, 3);
        chk("R5 upper bits ignored", last_data, 6'h3F);
        chk("R9 no SO on write", en_cnt, 0);
    endtask

    task automatic t_reads();
        logic [7:0] rx; logic e;
        frame(ID_OK, 8'h90, 1, 8'h00, rx, e);
        chk("R6 read wiper code", last_cmd, 0);
        chk("R6 read wiper byte", rx, 8'h15);
        chk("R6 read wiper SO enabled", e, 1);
        frame(ID_OK, 8'hB8, 1, 8'h00, rx, e);
        chk("R6 read DR code", last_cmd, 2);
        chk("R6 read DR select", last_sel, 2);
        chk("R6 read DR byte", rx, 8'h2A);
        frame(ID_OK, 8'h51, 1, 8'h00, rx, e);
        chk("R7 status code", last_cmd, 7);
        chk("R7 status byte", rx, 8'h01);
        chk("R9 SO off after frame", so_en_o, 0);
    endtask

    task automatic t_transfers();
        logic [7:0] rx; logic e;
        int s0, n0;
        s0 = stb_cnt; n0 = en_cnt;
        frame(ID_OK, 8'hD4, 0, 8'h00, rx, e);
        chk("R4 DR to wiper code", last_cmd, 4);
        chk("R4 DR to wiper select", last_sel, 1);
        frame(ID_OK, 8'hE8, 0, 8'h00, rx, e);
        chk("R4 wiper to DR code", last_cmd, 5);
        chk("R4 wiper to DR select", last_sel, 2);
        chk("R4 one strobe each", stb_cnt - s0, 2);
        chk("R4 no SO enable", en_cnt - n0, 0);
    endtask

    task automatic t_rejects();
        logic [7:0] rx; logic e;
        int s0, n0;
        s0 = stb_cnt; n0 = en_cnt;
        frame(ID_BAD, 8'h90, 1, 8'h00, rx, e);
        chk("R2 address mismatch no strobe", stb_cnt - s0, 0);
        chk("R2 address mismatch no SO", en_cnt - n0, 0);
        frame(8'h7D, 8'hA0, 1, 8'h11, rx, e);
        chk("R2 type mismatch no strobe", stb_cnt - s0, 0);
        frame(ID_OK, 8'h70, 1, 8'h00, rx, e);
        frame(ID_OK, 8'h53, 1, 8'h00, rx, e);
        chk("R11 unknown opcode no strobe", stb_cnt - s0, 0);
        chk("R11 unknown opcode no SO", en_cnt - n0, 0);
    endtask

    task automatic t_step();
        logic [7:0] d; logic e;
        int s0;
        s0 = stb_cnt;
        ups = 0; downs = 0;
        cs_begin();
        spi_byte(ID_OK, d, e, -1);
        spi_byte(8'h20, d, e, -1);
        chk("R8 no strobe for step instruction", stb_cnt - s0, 0);
        pulse(1); pulse(1); pulse(0); pulse(1); pulse(0);
        tick(H);
        cs_end();
        chk("R8 step count", stb_cnt - s0, 5);
        chk("R8 steps up", ups, 3);
        chk("R8 steps down", downs, 2);
        chk("R8 step code", last_cmd, 6);
    endtask

    task automatic t_hold();
        logic [7:0] rx, d; logic e;
        stb_cnt = 0;
        cs_begin();
        spi_byte(ID_OK, d, e, -1);
        spi_byte(8'hB4, d, e, -1);
        spi_byte(8'h00, rx, e, 3);
        cs_end();
        chk("R10 read resumes intact", rx, 8'h29);
        chk("R10 single strobe", stb_cnt, 1);
    endtask

    initial begin
        t_reset_and_start();
        t_writes();
        t_reads();
        t_transfers();
        t_rejects();
        t_step();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule